// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the base address registers of a configuration header into address windows and steers bus accesses to them. It takes six general base registers, one expansion ROM base register, a size per region, an I/O-or-memory type for each general region and the two space enable bits of the command register. On a remap strobe it computes, for every region, an aligned base, a last address and a valid flag, and holds them in a window table until the next strobe.

Each cycle an incoming bus address is classified as an I/O or a memory access. It is compared against every valid window of the same space. The registered result gives a hit flag, the index of the matching region (0 to 5 for the general registers, 6 for the ROM) and the offset of the address from the window base. Windows that wrap, that start at address zero, or that are I/O windows reaching past the 64K port space are never valid. The ROM window additionally needs its own enable bit.

Top module: `bar_window_decoder`

## Requirements
- R1: While rst_ni is low and after it rises, hit_o, region_o and offset_o are zero and every window is invalid until the first remap.
- R2: On remap, a region's base is its base register value ANDed with the complement of (size - 1), and its last address is base + size - 1. An access hits the region when base <= address <= last, and offset_o is then address - base.
- R3: On remap, an I/O region (is_io_i bit set) becomes valid only if cmd_i bit 0 is set. A memory region, including the ROM, becomes valid only if cmd_i bit 1 is set.
- R4: A window whose computed base is zero is invalid.
- R5: A window whose last address is not greater than its base is invalid. This covers 32-bit wrap and a size of 1.
- R6: An I/O window whose last address is 0x10000 or above is invalid.
- R7: The ROM window (region 6) is valid only if bit 0 of rom_bar_i is set at remap.
- R8: When several valid windows contain the address, region_o reports the lowest region index.
- R9: When no valid window matches, hit_o is 0 and region_o and offset_o are 0.
- R10: The window table changes only on a cycle with remap_i high. Changes to cmd_i, bar_i, rom_bar_i, size_i or is_io_i without a remap have no effect on the decode.
- R11: The outputs are registered. They reflect the bus address and space sampled at the previous rising clock edge.
- R12: An access matches only windows of its own space: bus_is_io_i = 1 selects I/O windows and bus_is_io_i = 0 selects memory windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| remap_i | input | 1 | Recompute and capture the window table |
| cmd_i | input | 2 | Space enables: bit 0 I/O, bit 1 memory |
| bar_i | input | 6x32 | General base address registers |
| rom_bar_i | input | 32 | Expansion ROM base register, bit 0 enables it |
| size_i | input | 7x32 | Region sizes, index 6 is the ROM |
| is_io_i | input | 6 | Region type per general register, 1 = I/O |
| bus_addr_i | input | 32 | Bus address to decode |
| bus_is_io_i | input | 1 | 1 = I/O access, 0 = memory access |
| hit_o | output | 1 | Registered hit flag |
| region_o | output | 3 | Registered index of the matched region |
| offset_o | output | 32 | Registered offset within the matched window |

## Verification
The hardest situations to reach are the held-table case and overlapping windows. In the first, the configuration inputs differ from what the decoder still uses. In the second, a lower and a higher region both cover an address. The bench rewrites a base register and clears the enables without strobing remap, then probes both the old and the new address before and after a later remap. It also places a small window inside a larger one to probe addresses in both. Each rejection rule is reached by a register value chosen to trip only that rule: a zero masked base, a size of 1, an I/O window just above 64K, and a ROM register with its enable bit clear.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned CMD_IO_BIT  = 0;
  localparam int unsigned CMD_MEM_BIT = 1;
  localparam int unsigned ROM_EN_BIT  = 0;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] last;
    logic              valid;
    logic              io;
  } window_t;
endpackage

// File: rtl/bar_window_calc.sv
module bar_window_calc
  import bar_dec_pkg::*;
#(
  parameter bit                ROM_SLOT = 1'b0,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] bar_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic              is_io_i,
  input  logic [1:0]        cmd_i,
  output window_t           win_o
);
  logic [ADDR_W-1:0] base, last;
  logic space_ok, rom_ok, io_ok;

  generate
    if (ROM_SLOT) begin : g_rom
      assign rom_ok = bar_i[ROM_EN_BIT];
    end else begin : g_bar
      assign rom_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    base     = bar_i & ~(size_i - ADDR_W'(1));
    last     = base + size_i - ADDR_W'(1);
    space_ok = is_io_i ? cmd_i[CMD_IO_BIT] : cmd_i[CMD_MEM_BIT];
    io_ok    = !is_io_i || (last < IO_LIMIT);
    win_o.base  = base;
    win_o.last  = last;
    win_o.io    = is_io_i;
    win_o.valid = space_ok && rom_ok && io_ok && (last > base) && (base != '0);
  end
endmodule

// File: rtl/bar_window_table.sv
module bar_window_table
  import bar_dec_pkg::*;
#(
  parameter int unsigned       NUM_BARS = 6,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 32'h0001_0000
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             remap_i,
  input  logic [1:0]                       cmd_i,
  input  logic [NUM_BARS-1:0][ADDR_W-1:0]  bar_i,
  input  logic [ADDR_W-1:0]                rom_bar_i,
  input  logic [NUM_BARS:0][ADDR_W-1:0]    size_i,
  input  logic [NUM_BARS-1:0]              is_io_i,
  output window_t [NUM_BARS:0]             win_q_o
);
  window_t [NUM_BARS:0] win_d;

  generate
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
      bar_window_calc #(.ROM_SLOT(1'b0), .IO_LIMIT(IO_LIMIT)) u_calc (
        .bar_i  (bar_i[g]),
        .size_i (size_i[g]),
        .is_io_i(is_io_i[g]),
        .cmd_i  (cmd_i),
        .win_o  (win_d[g])
      );
    end
  endgenerate

  // ROM region is always memory space
  bar_window_calc #(.ROM_SLOT(1'b1), .IO_LIMIT(IO_LIMIT)) u_rom_calc (
    .bar_i  (rom_bar_i),
    .size_i (size_i[NUM_BARS]),
    .is_io_i(1'b0),
    .cmd_i  (cmd_i),
    .win_o  (win_d[NUM_BARS])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q_o <= '0;
    else if (remap_i) win_q_o <= win_d;
  end
endmodule

// File: rtl/bar_window_match.sv
module bar_window_match
  import bar_dec_pkg::*;
#(
  parameter int unsigned REGIONS = 7,
  parameter int unsigned IDX_W   = 3
) (
  input  window_t [REGIONS-1:0] win_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  is_io_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [ADDR_W-1:0]     offset_o
);
  logic [ADDR_W-1:0] sel_base;

  // scan high to low so the lowest matching index is left standing
  always_comb begin
    hit_o    = 1'b0;
    idx_o    = '0;
    sel_base = '0;
    for (int i = REGIONS - 1; i >= 0; i--) begin
      if (win_i[i].valid && (win_i[i].io == is_io_i) &&
          (addr_i >= win_i[i].base) && (addr_i <= win_i[i].last)) begin
        hit_o    = 1'b1;
        idx_o    = IDX_W'(i);
        sel_base = win_i[i].base;
      end
    end
    offset_o = hit_o ? (addr_i - sel_base) : '0;
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bar_dec_pkg::*;
#(
  parameter int unsigned       NUM_BARS = 6,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 32'h0001_0000,
  localparam int unsigned      REGIONS  = NUM_BARS + 1,
  localparam int unsigned      IDX_W    = $clog2(NUM_BARS + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            remap_i,
  input  logic [1:0]                      cmd_i,
  input  logic [NUM_BARS-1:0][ADDR_W-1:0] bar_i,
  input  logic [ADDR_W-1:0]               rom_bar_i,
  input  logic [NUM_BARS:0][ADDR_W-1:0]   size_i,
  input  logic [NUM_BARS-1:0]             is_io_i,
  input  logic [ADDR_W-1:0]               bus_addr_i,
  input  logic                            bus_is_io_i,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                region_o,
  output logic [ADDR_W-1:0]               offset_o
);
  window_t [REGIONS-1:0] win_q;
  logic                  hit_d;
  logic [IDX_W-1:0]      idx_d;
  logic [ADDR_W-1:0]     offset_d;

  bar_window_table #(.NUM_BARS(NUM_BARS), .IO_LIMIT(IO_LIMIT)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .remap_i  (remap_i),
    .cmd_i    (cmd_i),
    .bar_i    (bar_i),
    .rom_bar_i(rom_bar_i),
    .size_i   (size_i),
    .is_io_i  (is_io_i),
    .win_q_o  (win_q)
  );

  bar_window_match #(.REGIONS(REGIONS), .IDX_W(IDX_W)) u_match (
    .win_i   (win_q),
    .addr_i  (bus_addr_i),
    .is_io_i (bus_is_io_i),
    .hit_o   (hit_d),
    .idx_o   (idx_d),
    .offset_o(offset_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o    <= 1'b0;
      region_o <= '0;
      offset_o <= '0;
    end else begin
      hit_o    <= hit_d;
      region_o <= idx_d;
      offset_o <= offset_d;
    end
  end
endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk
  import bar_dec_pkg::*;
#(
  parameter int unsigned       NUM_BARS = 6,
  parameter logic [ADDR_W-1:0] IO_LIMIT = 32'h0001_0000,
  parameter int unsigned       REGIONS  = 7,
  parameter int unsigned       IDX_W    = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  remap_i,
  input logic [1:0]            cmd_i,
  input logic [ADDR_W-1:0]     rom_bar_i,
  input logic [NUM_BARS-1:0]   is_io_i,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic                  bus_is_io_i,
  input logic                  hit_o,
  input logic [IDX_W-1:0]      region_o,
  input logic [ADDR_W-1:0]     offset_o,
  input window_t [REGIONS-1:0] win_q
);
  window_t [REGIONS-1:0] prev_win;
  logic [ADDR_W-1:0]     prev_addr;
  logic                  prev_io;
  logic                  any_match, lower_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_win  <= '0;
      prev_addr <= '0;
      prev_io   <= 1'b0;
    end else begin
      prev_win  <= win_q;
      prev_addr <= bus_addr_i;
      prev_io   <= bus_is_io_i;
    end
  end

  always_comb begin
    any_match   = 1'b0;
    lower_match = 1'b0;
    for (int j = 0; j < REGIONS; j++) begin
      if (prev_win[j].valid && prev_win[j].io == prev_io &&
          prev_addr >= prev_win[j].base && prev_addr <= prev_win[j].last) begin
        any_match = 1'b1;
        if (IDX_W'(j) < region_o) lower_match = 1'b1;
      end
    end
  end

  assert_region_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (region_o < IDX_W'(REGIONS)));

  // R11, R12: hit refers to the window table and address of the prior cycle
  assert_hit_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && region_o < IDX_W'(REGIONS)) |->
      (prev_win[region_o].valid && prev_win[region_o].io == prev_io &&
       prev_addr >= prev_win[region_o].base && prev_addr <= prev_win[region_o].last &&
       offset_o == prev_addr - prev_win[region_o].base));

  assert_lowest_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !lower_match);

  assert_miss_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (region_o == '0 && offset_o == '0 && !any_match));

  assert_table_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !remap_i |=> $stable(win_q));

  assert_rom_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_i |=> (!win_q[REGIONS-1].valid ||
                 ($past(rom_bar_i[ROM_EN_BIT]) && $past(cmd_i[CMD_MEM_BIT]))));

  generate
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_en
      assert_space_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        remap_i |=> (!win_q[g].valid ||
                     ($past(is_io_i[g]) ? $past(cmd_i[CMD_IO_BIT]) : $past(cmd_i[CMD_MEM_BIT]))));
    end
    for (genvar g = 0; g < REGIONS; g++) begin : g_win
      assert_base_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_q[g].valid |-> (win_q[g].base != '0));
      assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_q[g].valid |-> (win_q[g].last > win_q[g].base));
      assert_io_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_q[g].valid && win_q[g].io) |-> (win_q[g].last < IO_LIMIT));
    end
  endgenerate
endmodule

bind bar_window_decoder bar_window_decoder_chk #(
  .NUM_BARS(NUM_BARS), .IO_LIMIT(IO_LIMIT), .REGIONS(REGIONS), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .remap_i    (remap_i),
  .cmd_i      (cmd_i),
  .rom_bar_i  (rom_bar_i),
  .is_io_i    (is_io_i),
  .bus_addr_i (bus_addr_i),
  .bus_is_io_i(bus_is_io_i),
  .hit_o      (hit_o),
  .region_o   (region_o),
  .offset_o   (offset_o),
  .win_q      (win_q)
);

// File: tb/tb_bar_window_decoder.sv
module tb_bar_window_decoder;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             remap = 1'b0;
  logic [1:0]       cmd = '0;
  logic [5:0][31:0] bar = '0;
  logic [31:0]      rom_bar = '0;
  logic [6:0][31:0] size = '0;
  logic [5:0]       is_io = '0;
  logic [31:0]      addr = '0;
  logic             bus_io = 1'b0;
  logic             hit;
  logic [2:0]       region;
  logic [31:0]      offset;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bar_window_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .remap_i(remap), .cmd_i(cmd), .bar_i(bar),
    .rom_bar_i(rom_bar), .size_i(size), .is_io_i(is_io), .bus_addr_i(addr),
    .bus_is_io_i(bus_io), .hit_o(hit), .region_o(region), .offset_o(offset)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic io, input logic eh,
                       input logic [2:0] er, input logic [31:0] eo, input string req);
    @(negedge clk); addr = a; bus_io = io;
    @(negedge clk);
    chk(hit == eh, {req, " hit"}, 32'(hit), 32'(eh));
    chk(region == er, {req, " region"}, 32'(region), 32'(er));
    chk(offset == eo, {req, " offset"}, offset, eo);
  endtask

  task automatic do_remap();
    @(negedge clk); remap = 1'b1;
    @(negedge clk); remap = 1'b0;
  endtask

  task automatic clear_cfg();
    bar = '0; size = '0; is_io = '0; rom_bar = '0; cmd = 2'b11;
  endtask

  task automatic t_reset();
    #1;
    chk(hit == 1'b0 && region == '0 && offset == '0, "R1 in reset", {hit, region, offset[27:0]}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    bar[0] = 32'h8000_0000; size[0] = 32'h1000; cmd = 2'b11;
    probe(32'h8000_0010, 1'b0, 1'b0, 3'd0, 32'h0, "R1 no remap yet");
  endtask

  task automatic t_basic();
    clear_cfg();
    bar[0] = 32'h8000_0123; size[0] = 32'h1000;
    bar[1] = 32'h0000_C001; size[1] = 32'h20; is_io[1] = 1'b1;
    do_remap();
    probe(32'h8000_0010, 1'b0, 1'b1, 3'd0, 32'h10,  "R2 mem hit");
    probe(32'h8000_0FFF, 1'b0, 1'b1, 3'd0, 32'hFFF, "R2 mem last");
    probe(32'h8000_1000, 1'b0, 1'b0, 3'd0, 32'h0,   "R9 past last");
    probe(32'h7FFF_FFFF, 1'b0, 1'b0, 3'd0, 32'h0,   "R9 below base");
    probe(32'h0000_C01F, 1'b1, 1'b1, 3'd1, 32'h1F,  "R2 io hit");
    probe(32'h0000_C010, 1'b0, 1'b0, 3'd0, 32'h0,   "R12 mem access to io window");
    probe(32'h8000_0010, 1'b1, 1'b0, 3'd0, 32'h0,   "R12 io access to mem window");
  endtask

  task automatic t_enables();
    clear_cfg();
    bar[0] = 32'h8000_0000; size[0] = 32'h1000;
    bar[1] = 32'h0000_C000; size[1] = 32'h20; is_io[1] = 1'b1;
    cmd = 2'b01; do_remap();
    probe(32'h8000_0004, 1'b0, 1'b0, 3'd0, 32'h0, "R3 mem disabled");
    probe(32'h0000_C004, 1'b1, 1'b1, 3'd1, 32'h4, "R3 io enabled");
    cmd = 2'b10; do_remap();
    probe(32'h0000_C004, 1'b1, 1'b0, 3'd0, 32'h0, "R3 io disabled");
    probe(32'h8000_0004, 1'b0, 1'b1, 3'd0, 32'h4, "R3 mem enabled");
  endtask

  task automatic t_base_zero();
    clear_cfg();
    bar[2] = 32'h0000_0FFF; size[2] = 32'h1000;
    do_remap();
    probe(32'h0000_0010, 1'b0, 1'b0, 3'd0, 32'h0, "R4 zero base");
  endtask

  task automatic t_wrap();
    clear_cfg();
    bar[3] = 32'h9000_0000; size[3] = 32'h1;
    bar[4] = 32'hF000_0000; size[4] = 32'h1000_0000;
    do_remap();
    probe(32'h9000_0000, 1'b0, 1'b0, 3'd0, 32'h0,         "R5 size one");
    probe(32'hFFFF_FFFF, 1'b0, 1'b1, 3'd4, 32'h0FFF_FFFF, "R5 top of space");
  endtask

  task automatic t_io_limit();
    clear_cfg();
    bar[4] = 32'h0000_FF01; size[4] = 32'h100; is_io[4] = 1'b1;
    do_remap();
    probe(32'h0000_FFFF, 1'b1, 1'b1, 3'd4, 32'hFF, "R6 io at limit");
    bar[4] = 32'h0001_0001;
    do_remap();
    probe(32'h0001_0010, 1'b1, 1'b0, 3'd0, 32'h0, "R6 io above limit");
  endtask

  task automatic t_rom();
    clear_cfg();
    rom_bar = 32'hC000_0000; size[6] = 32'h1_0000;
    do_remap();
    probe(32'hC000_0020, 1'b0, 1'b0, 3'd0, 32'h0, "R7 rom disabled");
    rom_bar = 32'hC000_0001;
    do_remap();
    probe(32'hC000_0020, 1'b0, 1'b1, 3'd6, 32'h20, "R7 rom enabled");
    cmd = 2'b01; do_remap();
    probe(32'hC000_0020, 1'b0, 1'b0, 3'd0, 32'h0, "R3 rom needs mem enable");
  endtask

  task automatic t_priority();
    clear_cfg();
    bar[0] = 32'h8000_0000; size[0] = 32'h1000;
    bar[5] = 32'h8000_0000; size[5] = 32'h1_0000;
    rom_bar = 32'h8000_0001; size[6] = 32'h1_0000;
    do_remap();
    probe(32'h8000_0800, 1'b0, 1'b1, 3'd0, 32'h800,  "R8 lowest of three");
    probe(32'h8000_2000, 1'b0, 1'b1, 3'd5, 32'h2000, "R8 bar5 over rom");
  endtask

  task automatic t_hold();
    clear_cfg();
    bar[0] = 32'h8000_0000; size[0] = 32'h1000;
    do_remap();
    bar[0] = 32'hA000_0000; cmd = 2'b00;
    probe(32'h8000_0010, 1'b0, 1'b1, 3'd0, 32'h10, "R10 old window kept");
    probe(32'hA000_0010, 1'b0, 1'b0, 3'd0, 32'h0,  "R10 new window ignored");
    cmd = 2'b10; do_remap();
    probe(32'hA000_0010, 1'b0, 1'b1, 3'd0, 32'h10, "R10 new window after remap");
    probe(32'h8000_0010, 1'b0, 1'b0, 3'd0, 32'h0,  "R10 old window dropped");
  endtask

  task automatic t_latency();
    clear_cfg();
    bar[0] = 32'h8000_0000; size[0] = 32'h1000;
    do_remap();
    probe(32'h8000_0040, 1'b0, 1'b1, 3'd0, 32'h40, "R11 setup");
    @(negedge clk); addr = 32'h1234_0000;
    #1;
    chk(hit == 1'b1 && offset == 32'h40, "R11 before edge", offset, 32'h40);
    @(negedge clk);
    chk(hit == 1'b0 && offset == 32'h0, "R11 after edge", offset, 32'h0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_enables();
    t_base_zero();
    t_wrap();
    t_io_limit();
    t_rom();
    t_priority();
    t_hold();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule